// File: doc/BRIEF.md
# Byte-Wide Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit for two 8-bit operands. A 3-bit operation select picks one of eight functions: add, subtract, AND, OR, XOR, signed less-than compare, and logical shifts to the left and to the right. The block returns the 8-bit result together with four status flags: zero, negative, carry and signed overflow.

Add and subtract share one adder. For a subtract, the adder takes the inverted second operand with a carry-in of one. Carry on a subtract therefore means that no borrow occurred. The compare reuses the subtract path. The flags settle in the same evaluation as the result, so a surrounding datapath can register the result and the flags together on one edge.

Top module: `byte_alu`

## Requirements
- R1: Select 000 gives add: result = (A + B) mod 256.
- R2: Select 001 gives subtract: result = (A - B) mod 256, formed as A + ~B + 1.
- R3: Selects 010, 011 and 100 give the bitwise AND, OR and XOR of A and B.
- R4: Select 101 gives 0x01 when A < B as signed 8-bit values, and 0x00 otherwise. The decision is the sign of A - B XOR the overflow of A - B.
- R5: Select 110 shifts A left and select 111 shifts A right. Both shifts are logical. The amount is B[2:0] (0 to 7), and vacated bits are filled with zero.
- R6: The zero flag is 1 exactly when the 8-bit result is 0x00, for every select.
- R7: The negative flag equals result bit 7, for every select.
- R8: On add, carry is the carry out of bit 7. On subtract, carry is the carry out of A + ~B + 1. Examples: 0x00 - 0x01 gives carry 0, and 0x80 - 0x01 gives carry 1.
- R9: On add and subtract, the overflow flag is 1 exactly when the signed two's-complement result does not fit in 8 bits.
- R10: For selects 010 through 111, carry and overflow are 0.
- R11: The result and all four flags depend only on the present inputs and settle together, with no clock or latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand; bits 2:0 give the shift amount |
| op_i | input | 3 | Operation select |
| res_o | output | 8 | Result |
| zero_o | output | 1 | Result equals zero |
| neg_o | output | 1 | Result bit 7 |
| carry_o | output | 1 | Adder carry out (add and subtract only) |
| ovf_o | output | 1 | Signed overflow (add and subtract only) |

## Verification
Every output is due zero cycles after its inputs change, because there is no register anywhere in the block. The bench applies each stimulus, waits one time unit so that combinational settling can finish, and then samples all five outputs before the next stimulus. Flags are compared one at a time against an independent reference model, never derived from the result. This is done for a table of corner vectors and then for all operand pairs under every select.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_XOR = 3'b100,
    OP_SLT = 3'b101,
    OP_SHL = 3'b110,
    OP_SHR = 3'b111
  } alu_op_e;
endpackage

// File: rtl/byte_alu_addsub.sv
module byte_alu_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  always_comb begin
    b_eff   = sub_i ? ~b_i : b_i;
    full    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
    sum_o   = full[W-1:0];
    carry_o = full[W];
    // operands of equal sign, result of the other sign
    ovf_o   = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
  end

  always_comb begin
    if (sub_i && (a_i == b_i)) begin
      p_equal_sub_no_borrow_r8: assert (carry_o && (sum_o == '0));
    end
    if (ovf_o) begin
      p_ovf_sign_flip_r9: assert (sum_o[W-1] != a_i[W-1]);
    end
  end
endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic
  import byte_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      default: res_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/byte_alu_shift.sv
module byte_alu_shift #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]         a_i,
  input  logic [$clog2(W)-1:0] amt_i,
  input  logic                 left_i,
  output logic [W-1:0]         res_o
);
  localparam int unsigned SW = $clog2(W);

  logic [W-1:0] lstg [SW+1];
  logic [W-1:0] rstg [SW+1];

  assign lstg[0] = a_i;
  assign rstg[0] = a_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    assign lstg[k+1] = amt_i[k] ? (lstg[k] << (2**k)) : lstg[k];
    assign rstg[k+1] = amt_i[k] ? (rstg[k] >> (2**k)) : rstg[k];
  end

  assign res_o = left_i ? lstg[SW] : rstg[SW];

  always_comb begin
    if (amt_i != '0) begin
      if (left_i) begin
        p_shl_zero_fill_r5: assert (res_o[0] == 1'b0);
      end else begin
        p_shr_zero_fill_r5: assert (res_o[W-1] == 1'b0);
      end
    end
  end
endmodule

// File: rtl/byte_alu_flags.sv
module byte_alu_flags #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] res_i,
  input  logic         arith_i,
  input  logic         carry_i,
  input  logic         ovf_i,
  output logic         zero_o,
  output logic         neg_o,
  output logic         carry_o,
  output logic         ovf_o
);
  assign zero_o  = (res_i == '0);
  assign neg_o   = res_i[W-1];
  assign carry_o = arith_i & carry_i;
  assign ovf_o   = arith_i & ovf_i;
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [OP_W-1:0]   op_i,
  output logic [W-1:0]      res_o,
  output logic              zero_o,
  output logic              neg_o,
  output logic              carry_o,
  output logic              ovf_o
);
  localparam int unsigned SW = $clog2(W);

  alu_op_e      op;
  logic         sub;
  logic         arith;
  logic [W-1:0] sum;
  logic         add_c;
  logic         add_v;
  logic [W-1:0] logic_res;
  logic [W-1:0] shift_res;
  logic         lt;

  assign op    = alu_op_e'(op_i);
  assign sub   = (op != OP_ADD);  // compare rides the subtract path
  assign arith = (op == OP_ADD) || (op == OP_SUB);
  assign lt    = sum[W-1] ^ add_v;

  byte_alu_addsub #(.W(W)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(sub),
    .sum_o(sum), .carry_o(add_c), .ovf_o(add_v)
  );

  byte_alu_logic #(.W(W)) u_logic (
    .a_i(a_i), .b_i(b_i), .op_i(op), .res_o(logic_res)
  );

  byte_alu_shift #(.W(W)) u_shift (
    .a_i(a_i), .amt_i(b_i[SW-1:0]), .left_i(op == OP_SHL), .res_o(shift_res)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB:         res_o = sum;
      OP_AND, OP_OR, OP_XOR:  res_o = logic_res;
      OP_SLT:                 res_o = {{(W-1){1'b0}}, lt};
      default:                res_o = shift_res;
    endcase
  end

  byte_alu_flags #(.W(W)) u_flags (
    .res_i(res_o), .arith_i(arith), .carry_i(add_c), .ovf_i(add_v),
    .zero_o(zero_o), .neg_o(neg_o), .carry_o(carry_o), .ovf_o(ovf_o)
  );

  always_comb begin
    if (!arith) begin
      p_no_carry_ovf_r10: assert (!carry_o && !ovf_o);
    end
    if (op == OP_SLT) begin
      p_slt_range_r4: assert (res_o[W-1:1] == '0);
    end
    if (ovf_o) begin
      p_ovf_operand_signs_r9: assert (a_i[W-1] == (b_i[W-1] ^ (op == OP_SUB)));
    end
  end
endmodule

// File: tb/byte_alu_tb_top.sv
module byte_alu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic [7:0] a, b;
  logic [2:0] op;
  logic [7:0] res;
  logic       zf, nf, cf, vf;
  int         errors = 0;
  int         checks = 0;
  bit         done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_alu dut_i (
    .a_i(a), .b_i(b), .op_i(op),
    .res_o(res), .zero_o(zf), .neg_o(nf), .carry_o(cf), .ovf_o(vf)
  );

  // {op, a, b, res, z n c v}
  localparam logic [30:0] VEC [18] = '{
    {3'd0, 8'h7F, 8'h01, 8'h80, 4'b0101},
    {3'd0, 8'hFF, 8'h01, 8'h00, 4'b1010},
    {3'd0, 8'hF0, 8'h30, 8'h20, 4'b0010},
    {3'd0, 8'h80, 8'h80, 8'h00, 4'b1011},
    {3'd0, 8'h00, 8'h00, 8'h00, 4'b1000},
    {3'd1, 8'h00, 8'h01, 8'hFF, 4'b0100},
    {3'd1, 8'h80, 8'h01, 8'h7F, 4'b0011},
    {3'd1, 8'h05, 8'h05, 8'h00, 4'b1010},
    {3'd2, 8'hF0, 8'h3C, 8'h30, 4'b0000},
    {3'd3, 8'hF0, 8'h0F, 8'hFF, 4'b0100},
    {3'd4, 8'hAA, 8'hAA, 8'h00, 4'b1000},
    {3'd5, 8'h80, 8'h01, 8'h01, 4'b0000},
    {3'd5, 8'h01, 8'h80, 8'h00, 4'b1000},
    {3'd5, 8'hFF, 8'h00, 8'h01, 4'b0000},
    {3'd5, 8'h7F, 8'h80, 8'h00, 4'b1000},
    {3'd6, 8'h81, 8'h03, 8'h08, 4'b0000},
    {3'd7, 8'h81, 8'h0F, 8'h01, 4'b0000},
    {3'd7, 8'h80, 8'h07, 8'h01, 4'b0000}
  };

  function automatic string res_tag(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd5: return "R4";
      3'd6, 3'd7: return "R5";
      default: return "R3";
    endcase
  endfunction

  // independent model: {res, z, n, c, v}
  function automatic logic [11:0] model(input logic [2:0] o, input logic [7:0] x, input logic [7:0] y);
    int sx, sy, r;
    logic [7:0] q;
    logic c, v;
    sx = (x >= 128) ? int'(x) - 256 : int'(x);
    sy = (y >= 128) ? int'(y) - 256 : int'(y);
    c = 1'b0; v = 1'b0;
    case (o)
      3'd0: begin r = int'(x) + int'(y); q = r[7:0]; c = (r > 255); v = (sx + sy > 127) || (sx + sy < -128); end
      3'd1: begin q = 8'(int'(x) - int'(y)); c = (x >= y); v = (sx - sy > 127) || (sx - sy < -128); end
      3'd2: q = x & y;
      3'd3: q = x | y;
      3'd4: q = x ^ y;
      3'd5: q = (sx < sy) ? 8'h01 : 8'h00;
      3'd6: q = 8'((int'(x) * (2 ** int'(y[2:0]))) % 256);
      default: q = 8'(int'(x) / (2 ** int'(y[2:0])));
    endcase
    return {q, (q == 8'h00), q[7], c, v};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", tag, op, a, b, act, exp);
    end
  endtask

  // R11: outputs sampled one time unit after the stimulus, no clock involved
  task automatic apply(input logic [2:0] o, input logic [7:0] x, input logic [7:0] y,
                       input logic [7:0] er, input logic [3:0] ef);
    op = o; a = x; b = y;
    #1;
    check({res_tag(o), " R11 result"}, res, er);
    check("R6 zero", {7'd0, zf}, {7'd0, ef[3]});
    check("R7 negative", {7'd0, nf}, {7'd0, ef[2]});
    check((o < 3'd2) ? "R8 carry" : "R10 carry", {7'd0, cf}, {7'd0, ef[1]});
    check((o < 3'd2) ? "R9 overflow" : "R10 overflow", {7'd0, vf}, {7'd0, ef[0]});
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [11:0] m;
    op = 3'd0; a = 8'h00; b = 8'h00;
    #2;
    // idle state: all-zero inputs, add -> zero result, only Z set (R1, R6)
    check("R1 idle result", res, 8'h00);
    check("R6 idle zero", {7'd0, zf}, 8'h01);

    foreach (VEC[i]) begin
      apply(VEC[i][30:28], VEC[i][27:20], VEC[i][19:12], VEC[i][11:4], VEC[i][3:0]);
    end

    // exhaustive sweep against the model: every select, every operand pair
    for (int o = 0; o < 8; o++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          m = model(3'(o), 8'(x), 8'(y));
          apply(3'(o), 8'(x), 8'(y), m[11:4], m[3:0]);
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule